// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Controller

This block holds the completion flags, interrupt enables and IN-token handshake decision for a small USB device function. The function has a control endpoint (endpoint 0) with separate transmit and receive completion flags, and one transmit path that endpoints 1 and 2 share. The USB protocol engine reports a completed, host-acknowledged transmit or a completed receive as a one-cycle event pulse. Each pulse sets a sticky flag that the CPU sees through an 8-bit register port.

Software clears a flag by writing 1 to the same bit position in which the flag reads back. A transmit flag that has not been cleared holds the IN-token decision for its endpoint at NAK. The next packet goes out only when the flag is clear and the endpoint's transmit-enable input is high. A single level-sensitive interrupt request is the registered OR of every flag whose enable is set. There is no data stream at this block's edge, so all pins are plain control and status signals without valid/ready.

Top module: `usb_ep_irq_ctrl`

## Requirements
- R1: After reset all flags and interrupt enables are 0, `irq` is 0, and both registers read 0x00.
- R2: An event pulse on `ev_ep0_tx_ack`, `ev_ep0_rx_done` or `ev_ep12_tx_ack` sets its flag at that clock edge. The flag stays set until software clears it.
- R3: A write of 1 to a flag's bit position clears that flag. A write of 0 there leaves the flag unchanged. A write never sets a flag.
- R4: When an event and a clear write for the same flag fall in the same cycle, the flag ends up set.
- R5: The endpoint 1/2 register sits at `EP0_ADDR`+1. Bit 7 reads as the shared transmit flag and bit 3 is the read/write interrupt enable. All other bits read 0.
- R6: The endpoint 0 register sits at `EP0_ADDR`. Bit 7 is the transmit flag, bit 6 is the receive flag, bit 3 is the transmit enable and bit 2 is the receive enable. Bits 5, 4, 1 and 0 read 0.
- R7: The interrupt enable bits keep the last value written and do not change on any event.
- R8: `in_ep12_ready` is 1 exactly when the shared transmit flag is clear and `tx_en_ep12` is 1. `in_ep0_ready` follows the same rule with the endpoint 0 transmit flag and `tx_en_ep0`. A 0 means the next IN token is answered with NAK.
- R9: `irq` is 1 in the cycle after some flag and its enable are both 1. It returns to 0 in the cycle after no such pair remains.
- R10: A read of any other address, or with `reg_rd` low, returns 0x00. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational, 0 when not reading |
| ev_ep0_tx_ack | input | 1 | Endpoint 0 transmit acknowledged by host |
| ev_ep0_rx_done | input | 1 | Endpoint 0 receive completed |
| ev_ep12_tx_ack | input | 1 | Shared endpoint 1/2 transmit acknowledged |
| tx_en_ep0 | input | 1 | Endpoint 0 transmit enable |
| tx_en_ep12 | input | 1 | Endpoint 1/2 transmit enable |
| in_ep0_ready | output | 1 | Endpoint 0 IN decision: 1 data, 0 NAK |
| in_ep12_ready | output | 1 | Endpoint 1/2 IN decision: 1 data, 0 NAK |
| irq | output | 1 | Level interrupt request |

## Verification
A flag stuck high shows at once as NAK on the matching ready output, even with its enable clear. In the next cycle it also shows as a held `irq` when that enable is set. A lost set shows the other way: a register read returns the bit clear and the ready output stays high right after the event edge. A wrong enable or address decode shows on the next read of either register, or one cycle later as `irq` not following the flags.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;
  // flag / enable slot indices
  localparam int unsigned NUM_SLOTS   = 3;
  localparam int unsigned SLOT_EP0_TX = 0;
  localparam int unsigned SLOT_EP0_RX = 1;
  localparam int unsigned SLOT_EP12   = 2;

  // register bit positions (flag reads and clear writes share a position)
  localparam int unsigned POS_TX_FLAG = 7;
  localparam int unsigned POS_RX_FLAG = 6;
  localparam int unsigned POS_TX_IE   = 3;
  localparam int unsigned POS_RX_IE   = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EP0  = 2'd1,
    SEL_EP12 = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/usb_ep_flag_cell.sv
module usb_ep_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set has priority over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/usb_ep_reg_decode.sv
module usb_ep_reg_decode
  import usb_ep_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] EP0_ADDR = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 rd_i,
  input  logic [NUM_SLOTS-1:0] flags_i,
  input  logic [NUM_SLOTS-1:0] ie_i,
  output logic [NUM_SLOTS-1:0] clr_o,
  output logic [NUM_SLOTS-1:0] ie_we_o,
  output logic [NUM_SLOTS-1:0] ie_wval_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [ADDR_W-1:0] EP12_ADDR = EP0_ADDR + 1'b1;

  reg_sel_e sel;

  always_comb begin
    if (addr_i == EP0_ADDR)       sel = SEL_EP0;
    else if (addr_i == EP12_ADDR) sel = SEL_EP12;
    else                          sel = SEL_NONE;
  end

  always_comb begin
    clr_o     = '0;
    ie_we_o   = '0;
    ie_wval_o = '0;
    if (wr_i) begin
      unique case (sel)
        SEL_EP0: begin
          clr_o[SLOT_EP0_TX]     = wdata_i[POS_TX_FLAG];
          clr_o[SLOT_EP0_RX]     = wdata_i[POS_RX_FLAG];
          ie_we_o[SLOT_EP0_TX]   = 1'b1;
          ie_we_o[SLOT_EP0_RX]   = 1'b1;
          ie_wval_o[SLOT_EP0_TX] = wdata_i[POS_TX_IE];
          ie_wval_o[SLOT_EP0_RX] = wdata_i[POS_RX_IE];
        end
        SEL_EP12: begin
          clr_o[SLOT_EP12]     = wdata_i[POS_TX_FLAG];
          ie_we_o[SLOT_EP12]   = 1'b1;
          ie_wval_o[SLOT_EP12] = wdata_i[POS_TX_IE];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        SEL_EP0: begin
          rdata_o[POS_TX_FLAG] = flags_i[SLOT_EP0_TX];
          rdata_o[POS_RX_FLAG] = flags_i[SLOT_EP0_RX];
          rdata_o[POS_TX_IE]   = ie_i[SLOT_EP0_TX];
          rdata_o[POS_RX_IE]   = ie_i[SLOT_EP0_RX];
        end
        SEL_EP12: begin
          rdata_o[POS_TX_FLAG] = flags_i[SLOT_EP12];
          rdata_o[POS_TX_IE]   = ie_i[SLOT_EP12];
        end
        default: ;
      endcase
    end
  end

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i || sel == SEL_NONE) |-> (rdata_o == '0));
  p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (clr_o == '0 && ie_we_o == '0));
endmodule

// File: rtl/usb_ep_irq_merge.sv
module usb_ep_irq_merge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] ie_i,
  output logic         irq_o
);
  logic pending;
  assign pending = |(flags_i & ie_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending;
  end
endmodule

// File: rtl/usb_ep_irq_ctrl.sv
module usb_ep_irq_ctrl
  import usb_ep_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] EP0_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_ep0_tx_ack,
  input  logic              ev_ep0_rx_done,
  input  logic              ev_ep12_tx_ack,
  input  logic              tx_en_ep0,
  input  logic              tx_en_ep12,
  output logic              in_ep0_ready,
  output logic              in_ep12_ready,
  output logic              irq
);
  logic [NUM_SLOTS-1:0] ev_set;
  logic [NUM_SLOTS-1:0] flags;
  logic [NUM_SLOTS-1:0] clr;
  logic [NUM_SLOTS-1:0] ie_q;
  logic [NUM_SLOTS-1:0] ie_we;
  logic [NUM_SLOTS-1:0] ie_wval;

  assign ev_set[SLOT_EP0_TX] = ev_ep0_tx_ack;
  assign ev_set[SLOT_EP0_RX] = ev_ep0_rx_done;
  assign ev_set[SLOT_EP12]   = ev_ep12_tx_ack;

  usb_ep_reg_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .EP0_ADDR(EP0_ADDR)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr),
    .wr_i     (reg_wr),
    .wdata_i  (reg_wdata),
    .rd_i     (reg_rd),
    .flags_i  (flags),
    .ie_i     (ie_q),
    .clr_o    (clr),
    .ie_we_o  (ie_we),
    .ie_wval_o(ie_wval),
    .rdata_o  (reg_rdata)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    usb_ep_flag_cell u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set[g]),
      .clr_i (clr[g]),
      .flag_o(flags[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ie_q[g] <= 1'b0;
      else if (ie_we[g]) ie_q[g] <= ie_wval[g];
    end

    p_ie_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_we[g] |=> $stable(ie_q[g]));
  end

  // IN-token decision: data only when the previous packet was retired
  assign in_ep0_ready  = tx_en_ep0  & ~flags[SLOT_EP0_TX];
  assign in_ep12_ready = tx_en_ep12 & ~flags[SLOT_EP12];

  usb_ep_irq_merge #(.N(NUM_SLOTS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags_i(flags),
    .ie_i   (ie_q),
    .irq_o  (irq)
  );

  p_nak_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ep12_tx_ack |=> !in_ep12_ready);
  p_nak_ep0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ep0_tx_ack |=> !in_ep0_ready);
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ie_q)) |=> irq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & ie_q)) |=> !irq);
endmodule

// File: tb/usb_ep_irq_ctrl_tb.sv
module usb_ep_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_EP0  = 8'h40;
  localparam logic [7:0] A_EP12 = 8'h41;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       ev_ep0_tx_ack = 1'b0, ev_ep0_rx_done = 1'b0, ev_ep12_tx_ack = 1'b0;
  logic       tx_en_ep0 = 1'b0, tx_en_ep12 = 1'b0;
  logic       in_ep0_ready, in_ep12_ready, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ev_ep0_tx_ack(ev_ep0_tx_ack), .ev_ep0_rx_done(ev_ep0_rx_done),
    .ev_ep12_tx_ack(ev_ep12_tx_ack),
    .tx_en_ep0(tx_en_ep0), .tx_en_ep12(tx_en_ep12),
    .in_ep0_ready(in_ep0_ready), .in_ep12_ready(in_ep12_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(A_EP0, d);  check("R1 ep0 reg", d, 8'h00);
    rd(A_EP12, d); check("R1 ep12 reg", d, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(A_EP0, 8'hFF);  rd(A_EP0, d);  check("R6 ep0 layout", d, 8'h0C);
    wr(A_EP12, 8'hFF); rd(A_EP12, d); check("R5 ep12 layout", d, 8'h08);
    wr(A_EP0, 8'h04);  rd(A_EP0, d);  check("R7 ie write", d, 8'h04);
    wr(A_EP0, 8'h0C);  rd(A_EP0, d);  check("R7 ie rewrite", d, 8'h0C);
    check("R9 no flag no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ep0_flags();
    logic [7:0] d;
    @(negedge clk) ev_ep0_tx_ack = 1'b1;
    @(negedge clk) ev_ep0_tx_ack = 1'b0;
    rd(A_EP0, d); check("R2 ep0 tx set", d, 8'h8C);
    repeat (3) @(negedge clk);
    rd(A_EP0, d); check("R2 ep0 tx sticky", d, 8'h8C);
    wr(A_EP0, 8'h0C); rd(A_EP0, d); check("R3 zero write no effect", d, 8'h8C);
    wr(A_EP0, 8'h8C); rd(A_EP0, d); check("R3 clear tx", d, 8'h0C);
    @(negedge clk) ev_ep0_rx_done = 1'b1;
    @(negedge clk) ev_ep0_rx_done = 1'b0;
    rd(A_EP0, d); check("R2 ep0 rx set", d, 8'h4C);
    wr(A_EP0, 8'h4C); rd(A_EP0, d); check("R3 clear rx", d, 8'h0C);
  endtask

  task automatic t_nak();
    tx_en_ep12 = 1'b1; tx_en_ep0 = 1'b1;
    @(negedge clk);
    check("R8 ep12 ready", {7'd0, in_ep12_ready}, 8'h01);
    check("R8 ep0 ready", {7'd0, in_ep0_ready}, 8'h01);
    @(negedge clk) ev_ep12_tx_ack = 1'b1;
    @(negedge clk) ev_ep12_tx_ack = 1'b0;
    check("R8 ep12 nak after ack", {7'd0, in_ep12_ready}, 8'h00);
    check("R8 ep0 unaffected", {7'd0, in_ep0_ready}, 8'h01);
    wr(A_EP12, 8'h88);
    check("R8 ep12 ready after clear", {7'd0, in_ep12_ready}, 8'h01);
    tx_en_ep12 = 1'b0;
    #1 check("R8 ep12 nak when disabled", {7'd0, in_ep12_ready}, 8'h00);
    @(negedge clk) ev_ep0_tx_ack = 1'b1;
    @(negedge clk) ev_ep0_tx_ack = 1'b0;
    check("R8 ep0 nak after ack", {7'd0, in_ep0_ready}, 8'h00);
    wr(A_EP0, 8'h8C);
    check("R8 ep0 ready after clear", {7'd0, in_ep0_ready}, 8'h01);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk);
    reg_addr = A_EP12; reg_wdata = 8'h88; reg_wr = 1'b1; ev_ep12_tx_ack = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_ep12_tx_ack = 1'b0;
    rd(A_EP12, d); check("R4 set beats clear", d, 8'h88);
    wr(A_EP12, 8'h88); rd(A_EP12, d); check("R3 ep12 clear", d, 8'h08);
  endtask

  task automatic t_irq();
    wr(A_EP0, 8'h00);           // ep0 enables off, ep12 enable still on
    @(negedge clk) ev_ep12_tx_ack = 1'b1;
    @(negedge clk) ev_ep12_tx_ack = 1'b0;
    check("R9 irq one cycle late", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq raised", {7'd0, irq}, 8'h01);
    wr(A_EP12, 8'h00);          // disable, flag stays
    check("R9 irq lags disable", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);
    @(negedge clk) ev_ep0_rx_done = 1'b1;
    @(negedge clk) ev_ep0_rx_done = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 disabled flag no irq", {7'd0, irq}, 8'h00);
    wr(A_EP0, 8'h04);
    @(negedge clk);
    check("R9 enable raises irq", {7'd0, irq}, 8'h01);
    wr(A_EP0, 8'h44);
    @(negedge clk);
    check("R9 clear drops irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic [7:0] d;
    wr(8'h42, 8'hFF); rd(8'h42, d); check("R10 foreign read", d, 8'h00);
    wr(8'h3F, 8'hFF);
    rd(A_EP0, d);  check("R10 ep0 untouched", d, 8'h04);
    rd(A_EP12, d); check("R10 ep12 untouched", d, 8'h80);
    @(negedge clk) reg_addr = A_EP12;
    #1 check("R10 no strobe reads zero", reg_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_ep0_flags();
    t_nak();
    t_set_wins();
    t_irq();
    t_bad_addr();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule